// File: doc/BRIEF.md
# Island Address Route Decoder

This block works out which island a bus address will reach. Its inputs are a bus address, a target code, a 3-bit translation mode, a wide-address flag and a pair of 6-bit base island IDs. Its outputs are the destination island ID and an error flag. The translation mode sets which address bits carry routing information:

- In the direct-field mode, a 6-bit slice of the address is the island ID.
- In the other three modes, an index bit chooses one of the two base islands. Zero, one or two address bits directly below the index bit then replace the low bits of the chosen base.

The block does not rewrite addresses and does not look up tables. It also does not check that the island it reports exists; the caller must do that. Memory-unit targets use a different address layout, and so do crossbar-peripheral targets. The block rejects both.

A parameter sets whether the result is registered, with one cycle of latency, or passed straight through from the inputs.

Top module: `island_route_decoder`

## Requirements
- R1: With mode 0, islandOut equals busAddr[39:34] when wideAddr is 1 and busAddr[31:26] when wideAddr is 0.
- R2: With mode 1, the index bit is busAddr[39] (wideAddr=1) or busAddr[31] (wideAddr=0). islandOut is baseIsland1 when the index bit is 1 and baseIsland0 when it is 0.
- R3: With mode 2, bit 0 of the chosen base is replaced by the address bit directly below the index bit, which is busAddr[38] (wide) or busAddr[30] (narrow).
- R4: With mode 3, bits 1:0 of the chosen base are replaced by the two address bits directly below the index bit, which are busAddr[38:37] (wide) or busAddr[30:29] (narrow).
- R5: Target code 7 (memory unit) and target code 14 (crossbar peripheral) set routeErr to 1 in every mode.
- R6: Mode values 4 to 7 set routeErr to 1 for any target.
- R7: For every other target code and modes 0 to 3, routeErr is 0. islandOut reports the selected pattern unfiltered, including IDs such as 63.
- R8: While routeErr is 1, islandOut is 0.
- R9: With REG_OUT=1, a change on the inputs first appears on the outputs after the next rising clock edge, and the outputs hold their previous values until that edge. With REG_OUT=0, the outputs follow the inputs within the same cycle.
- R10: While rstN is low with REG_OUT=1, islandOut is 0 and routeErr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 40 | Bus address to decode |
| tgtCode | input | 4 | Target code |
| xlatMode | input | 3 | Translation mode |
| wideAddr | input | 1 | 1 selects 40-bit field positions, 0 selects 32-bit ones |
| baseIsland0 | input | 6 | Base island chosen when the index bit is 0 |
| baseIsland1 | input | 6 | Base island chosen when the index bit is 1 |
| islandOut | output | 6 | Decoded destination island |
| routeErr | output | 1 | Unsupported target or mode |

## Verification
With the default registered build, each stimulus applied at a falling edge is due on the outputs after the next rising edge. The driver puts every expected island and error value in a queue when it applies the stimulus. The monitor takes one entry off the queue two nanoseconds after each rising edge, so each comparison falls within the cycle in which that result is valid. A separate latency check samples the outputs in the half cycle after a new stimulus is applied. At that point they must still show the previous result.

// File: rtl/island_route_pkg.sv
package island_route_pkg;
  // Strobes from control to datapath: exactly one of the use*/reject bits is set.
  typedef struct packed {
    logic useField;  // island taken straight from an address slice
    logic usePick;   // index bit picks a whole base island
    logic useLow1;   // picked base with one low bit from the address
    logic useLow2;   // picked base with two low bits from the address
    logic wide;      // 40-bit field positions
    logic reject;    // unsupported target or mode
  } routeStrobes_t;
endpackage

// File: rtl/ird_ctrl.sv
module ird_ctrl
  import island_route_pkg::*;
#(
  parameter int TGT_W     = 4,
  parameter int MODE_W    = 3,
  parameter int MEM_CODE  = 7,
  parameter int XBAR_CODE = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TGT_W-1:0]  tgtCode,
  input  logic [MODE_W-1:0] xlatMode,
  input  logic              wideAddr,
  output routeStrobes_t     strobes
);
  localparam logic [TGT_W-1:0] MemTgt  = TGT_W'(MEM_CODE);
  localparam logic [TGT_W-1:0] XbarTgt = TGT_W'(XBAR_CODE);

  logic badTgt;
  assign badTgt = (tgtCode == MemTgt) || (tgtCode == XbarTgt);

  always_comb begin
    strobes      = '0;
    strobes.wide = wideAddr;
    if (badTgt) begin
      strobes.reject = 1'b1;
    end else begin
      case (xlatMode)
        MODE_W'(0): strobes.useField = 1'b1;
        MODE_W'(1): strobes.usePick  = 1'b1;
        MODE_W'(2): strobes.useLow1  = 1'b1;
        MODE_W'(3): strobes.useLow2  = 1'b1;
        default:    strobes.reject   = 1'b1;
      endcase
    end
  end

  // R7: exactly one decode path, or the reject path, is active.
  assert_single_path_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.useField, strobes.usePick, strobes.useLow1,
                strobes.useLow2, strobes.reject}) == 1);

  // R5: a rejected target never reaches a decode path.
  assert_tgt_blocks_decode_R5: assert property (@(posedge clk) disable iff (!rstN)
    badTgt |-> !(strobes.useField || strobes.usePick || strobes.useLow1 || strobes.useLow2));
endmodule

// File: rtl/ird_datapath.sv
module ird_datapath
  import island_route_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int NARROW_W = 32,
  parameter int ISL_W    = 6,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  routeStrobes_t     strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ISL_W-1:0]  baseIsland0,
  input  logic [ISL_W-1:0]  baseIsland1,
  output logic [ISL_W-1:0]  islandOut,
  output logic              routeErr
);
  localparam int WideIdx   = ADDR_W - 1;
  localparam int NarrowIdx = NARROW_W - 1;

  logic             idxBit;
  logic [ISL_W-1:0] fieldVal;
  logic [1:0]       lowBits;
  logic [ISL_W-1:0] pickedBase;
  logic [ISL_W-1:0] nextIsland;
  logic             nextErr;
  logic             unusedAddr;

  assign unusedAddr = ^busAddr;

  always_comb begin
    if (strobes.wide) begin
      idxBit   = busAddr[WideIdx];
      fieldVal = busAddr[WideIdx -: ISL_W];
      lowBits  = busAddr[WideIdx-1 -: 2];
    end else begin
      idxBit   = busAddr[NarrowIdx];
      fieldVal = busAddr[NarrowIdx -: ISL_W];
      lowBits  = busAddr[NarrowIdx-1 -: 2];
    end
    pickedBase = idxBit ? baseIsland1 : baseIsland0;

    nextIsland = '0;
    if (strobes.useField)     nextIsland = fieldVal;
    else if (strobes.usePick) nextIsland = pickedBase;
    else if (strobes.useLow1) nextIsland = {pickedBase[ISL_W-1:1], lowBits[1]};
    else if (strobes.useLow2) nextIsland = {pickedBase[ISL_W-1:2], lowBits};
    nextErr = strobes.reject;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          islandOut <= '0;
          routeErr  <= 1'b0;
        end else begin
          islandOut <= nextIsland;
          routeErr  <= nextErr;
        end
      end
    end else begin : g_comb
      assign islandOut = nextIsland;
      assign routeErr  = nextErr;
    end
  endgenerate

  // R8: an error output never carries an island value.
  assert_zero_on_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    routeErr |-> (islandOut == '0));
endmodule

// File: rtl/island_route_decoder.sv
module island_route_decoder
  import island_route_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NARROW_W  = 32,
  parameter int ISL_W     = 6,
  parameter int TGT_W     = 4,
  parameter int MODE_W    = 3,
  parameter int MEM_CODE  = 7,
  parameter int XBAR_CODE = 14,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [TGT_W-1:0]  tgtCode,
  input  logic [MODE_W-1:0] xlatMode,
  input  logic              wideAddr,
  input  logic [ISL_W-1:0]  baseIsland0,
  input  logic [ISL_W-1:0]  baseIsland1,
  output logic [ISL_W-1:0]  islandOut,
  output logic              routeErr
);
  routeStrobes_t strobes;

  ird_ctrl #(
    .TGT_W(TGT_W), .MODE_W(MODE_W), .MEM_CODE(MEM_CODE), .XBAR_CODE(XBAR_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tgtCode(tgtCode), .xlatMode(xlatMode),
    .wideAddr(wideAddr), .strobes(strobes)
  );

  ird_datapath #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .ISL_W(ISL_W), .REG_OUT(REG_OUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .baseIsland0(baseIsland0), .baseIsland1(baseIsland1),
    .islandOut(islandOut), .routeErr(routeErr)
  );

  // Port-level checks, with latency set by REG_OUT.
  logic tgtBad;
  logic modeBad;
  logic pickIdx;
  assign tgtBad  = (tgtCode == TGT_W'(MEM_CODE)) || (tgtCode == TGT_W'(XBAR_CODE));
  assign modeBad = xlatMode > MODE_W'(3);
  assign pickIdx = wideAddr ? busAddr[ADDR_W-1] : busAddr[NARROW_W-1];

  generate
    if (REG_OUT) begin : g_chk_reg
      assert_tgt_err_R5: assert property (@(posedge clk) disable iff (!rstN)
        tgtBad |=> routeErr);
      assert_mode_err_R6: assert property (@(posedge clk) disable iff (!rstN)
        modeBad |=> routeErr);
      assert_pick_base_R2: assert property (@(posedge clk) disable iff (!rstN)
        (!tgtBad && xlatMode == MODE_W'(1)) |=>
          (islandOut == ($past(pickIdx) ? $past(baseIsland1) : $past(baseIsland0))));
      assert_ok_no_err_R7: assert property (@(posedge clk) disable iff (!rstN)
        (!tgtBad && !modeBad) |=> !routeErr);
    end else begin : g_chk_comb
      assert_tgt_err_R5: assert property (@(posedge clk) disable iff (!rstN)
        tgtBad |-> routeErr);
      assert_mode_err_R6: assert property (@(posedge clk) disable iff (!rstN)
        modeBad |-> routeErr);
      assert_pick_base_R2: assert property (@(posedge clk) disable iff (!rstN)
        (!tgtBad && xlatMode == MODE_W'(1)) |->
          (islandOut == (pickIdx ? baseIsland1 : baseIsland0)));
      assert_ok_no_err_R7: assert property (@(posedge clk) disable iff (!rstN)
        (!tgtBad && !modeBad) |-> !routeErr);
    end
  endgenerate
endmodule

// File: tb/island_route_decoder_tb.sv
module island_route_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] busAddr = '0;
  logic [3:0]  tgtCode = '0;
  logic [2:0]  xlatMode = '0;
  logic        wideAddr = 1'b0;
  logic [5:0]  baseIsland0 = '0;
  logic [5:0]  baseIsland1 = '0;
  logic [5:0]  islandOut;
  logic        routeErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0] isl;
    logic       err;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  island_route_decoder u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .tgtCode(tgtCode),
    .xlatMode(xlatMode), .wideAddr(wideAddr), .baseIsland0(baseIsland0),
    .baseIsland1(baseIsland1), .islandOut(islandOut), .routeErr(routeErr)
  );

  // Reference model written from the requirement text.
  function automatic expItem_t model(logic [3:0] t, logic [2:0] m, logic w,
                                     logic [39:0] a, logic [5:0] b0, logic [5:0] b1);
    expItem_t r;
    logic ix;
    logic [5:0] base;
    r.isl = 6'd0;
    r.err = 1'b0;
    ix   = w ? a[39] : a[31];
    base = ix ? b1 : b0;
    if (t == 4'd7 || t == 4'd14) begin
      r.err = 1'b1; r.req = "R5";
    end else if (m == 3'd0) begin
      r.isl = w ? a[39:34] : a[31:26]; r.req = "R1";
    end else if (m == 3'd1) begin
      r.isl = base; r.req = "R2";
    end else if (m == 3'd2) begin
      r.isl = {base[5:1], (w ? a[38] : a[30])}; r.req = "R3";
    end else if (m == 3'd3) begin
      r.isl = {base[5:2], (w ? a[38:37] : a[30:29])}; r.req = "R4";
    end else begin
      r.err = 1'b1; r.req = "R6";
    end
    return r;
  endfunction

  task automatic check(string req, logic [5:0] gotI, logic gotE,
                       logic [5:0] expI, logic expE);
    checks++;
    if (gotI !== expI || gotE !== expE) begin
      fails++;
      $display("FAIL %s: island=%0d err=%0b expected island=%0d err=%0b",
               req, gotI, gotE, expI, expE);
    end
  endtask

  task automatic drive(logic [3:0] t, logic [2:0] m, logic w, logic [39:0] a,
                       logic [5:0] b0, logic [5:0] b1, string tag);
    expItem_t e;
    @(negedge clk);
    tgtCode = t; xlatMode = m; wideAddr = w; busAddr = a;
    baseIsland0 = b0; baseIsland1 = b1;
    e = model(t, m, w, a, b0, b1);
    if (tag != "") e.req = tag;
    expQ.push_back(e);
  endtask

  // Monitor: one result per rising edge, sampled 2 ns later.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.req, islandOut, routeErr, e.isl, e.err);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset holds outputs at zero even with a decodable stimulus.
    tgtCode = 4'd1; xlatMode = 3'd1; baseIsland0 = 6'd21; baseIsland1 = 6'd42;
    repeat (3) @(negedge clk);
    check("R10", islandOut, routeErr, 6'd0, 1'b0);
    rstN = 1'b1;

    // R1 direct field, both widths, plus an unvalidated pattern (R7).
    drive(4'd1, 3'd0, 1'b1, 40'h2C_0000_0000, 6'd0, 6'd0, "R1");   // [39:34]=11
    drive(4'd1, 3'd0, 1'b0, 40'h00_4C00_0000, 6'd0, 6'd0, "R1");   // [31:26]=19
    drive(4'd3, 3'd0, 1'b1, 40'hFC_0000_0000, 6'd0, 6'd0, "R7");   // 63
    // R2 index picks base.
    drive(4'd1, 3'd1, 1'b1, 40'h80_0000_0000, 6'd5, 6'd40, "R2");
    drive(4'd1, 3'd1, 1'b1, 40'h00_8000_0000, 6'd5, 6'd40, "R2");  // bit31 ignored when wide
    drive(4'd1, 3'd1, 1'b0, 40'h00_8000_0000, 6'd5, 6'd40, "R2");
    // R3 one low bit.
    drive(4'd2, 3'd2, 1'b1, 40'hC0_0000_0000, 6'd4, 6'd13, "R3");  // 12|1=13
    drive(4'd2, 3'd2, 1'b0, 40'h00_0000_0000, 6'd7, 6'd13, "R3");  // 6
    // R4 two low bits.
    drive(4'd9, 3'd3, 1'b1, 40'hA0_0000_0000, 6'd3, 6'd47, "R4");  // 44|1=45
    drive(4'd9, 3'd3, 1'b0, 40'h00_6000_0000, 6'd31, 6'd0, "R4");  // 28|3=31
    // R5/R6/R8 errors.
    drive(4'd7, 3'd0, 1'b1, 40'hFC_0000_0000, 6'd9, 6'd9, "R5");
    drive(4'd14, 3'd1, 1'b0, 40'h00_8000_0000, 6'd9, 6'd9, "R5");
    drive(4'd1, 3'd4, 1'b1, 40'hFF_FFFF_FFFF, 6'd9, 6'd9, "R6");
    drive(4'd0, 3'd7, 1'b0, 40'hFF_FFFF_FFFF, 6'd9, 6'd9, "R8");
    drive(4'd15, 3'd1, 1'b0, 40'h00_0000_0000, 6'd33, 6'd9, "R7");

    // R9: new inputs do not show before the next rising edge.
    drive(4'd1, 3'd1, 1'b0, 40'h0, 6'd17, 6'd2, "R9");
    @(negedge clk);
    tgtCode = 4'd1; xlatMode = 3'd1; wideAddr = 1'b0; busAddr = 40'h0;
    baseIsland0 = 6'd50; baseIsland1 = 6'd2;
    #1;
    check("R9", islandOut, routeErr, 6'd17, 1'b0);
    expQ.push_back('{isl: 6'd50, err: 1'b0, req: "R9"});

    for (int i = 0; i < 300; i++) begin
      drive(4'($urandom), 3'($urandom), 1'($urandom), {8'($urandom), 32'($urandom)},
            6'($urandom), 6'($urandom), "");
    end
    @(negedge clk);
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule